// File: doc/BRIEF.md
# Interrupt Line Routing Configuration Registers

This block holds the configuration bytes of a bus-to-legacy bridge function that steer four shared interrupt lines onto sixteen legacy IRQ numbers. Each line owns one routing byte. Software writes an IRQ number into that byte to attach the line, or a value with the top bit set to detach it. Next to the routing bytes the block keeps a reverse table with one bit per line for each IRQ. Its OR per IRQ is driven out as a sixteen-bit in-use vector. An interrupt controller uses this vector to learn which legacy inputs now carry shared interrupts.

The same block applies the bridge's write rules to a few neighbouring bytes. These are the command byte, a pair of status bytes, a write-protect control byte and two miscellaneous bytes. Some bits are forced, some are masked off, and some clear when software writes a one to them. Accesses arrive as an offset, a size of one, two or four bytes and a data word. Reads are combinational. Writes take effect at the next rising clock edge.

Top module: `irq_route_cfg`

## Requirements
- R1: After reset all four routing bytes (offsets 0x60..0x63) read 0x80, the command byte at 0x04 reads 0x07, the upper status byte at 0x07 reads 0x02, every other offset reads 0x00 and the in-use vector is zero.
- R2: A write to routing byte 0x60+p stores the written byte ANDed with 0x8F when it is accepted. A stored value with bit 7 set means line p is detached and contributes to no IRQ.
- R3: A value with bit 7 clear is accepted only when bit n of the constant 0xDEF8 is set, where n is the low four bits. Any other such value leaves the routing byte and the in-use vector unchanged.
- R4: In-use bit n is one exactly when at least one line's routing byte has bit 7 clear and low nibble n. Re-routing a line drops it from its old IRQ and adds it to the new one.
- R5: The in-use vector still shows the old routing before the clock edge that takes a routing write, and the new routing from that edge onward. Without a write it does not change.
- R6: The size code selects the bytes written: 0 selects one byte, 1 selects two, and 2 or 3 select four. Data byte i goes to offset cfg_off+i, and bytes beyond the end of the aligned dword are dropped. A read returns the aligned dword shifted right by 8*cfg_off[1:0].
- R7: A write covering offset 0x04 stores (byte & 0x08) | 0x07. A write covering offset 0x05 stores byte & 0x01.
- R8: A write covering offset 0x07 clears the old bits selected by (byte & 0x78), keeps the other old bits and forces bit 1 to one.
- R9: Offset 0x4F stores byte & 0x01, offset 0x6A stores byte & 0xD7 and offset 0x80 stores byte & 0x7F.
- R10: Writes to offset 0x06 and to offsets 0x10..0x33 have no effect. Offsets that hold no register read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Write strobe for one access |
| cfg_off | input | 8 | Byte offset of the access |
| cfg_size | input | 2 | Size code: 0 one byte, 1 two bytes, 2 or 3 four bytes |
| cfg_wdata | input | 32 | Write data, byte 0 going to cfg_off |
| cfg_rdata | output | 32 | Read data for cfg_off, combinational |
| irq_busy | output | 16 | In-use vector, one bit per IRQ |

## Verification
On every cycle, the assertions check that the reverse table behind the in-use vector agrees with the routing bytes. They also check that no illegal IRQ is ever attached or flagged, that the in-use vector holds still without a write, and that the forced bits of the command byte and the upper status byte stay in place. The exact stored value for every byte value at every routing and special offset can only be shown by the bench's scenarios. The same goes for the lane placement of multi-byte and clipped writes, the shift applied to read data and the ignored offsets. The bench sweeps all 256 byte values over each routing and rule offset and compares the result with a byte model of its own.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int unsigned CFG_AW   = 8;
  localparam int unsigned LANES    = 4;
  localparam int unsigned N_MISC   = 6;

  localparam logic [7:0] OFF_CMD_LO  = 8'h04;
  localparam logic [7:0] OFF_CMD_HI  = 8'h05;
  localparam logic [7:0] OFF_STS_LO  = 8'h06;
  localparam logic [7:0] OFF_STS_HI  = 8'h07;
  localparam logic [7:0] OFF_WPROT   = 8'h4F;
  localparam logic [7:0] OFF_AUX_A   = 8'h6A;
  localparam logic [7:0] OFF_AUX_B   = 8'h80;
  localparam logic [7:0] ROUTE_BASE  = 8'h60;
  localparam logic [7:0] LOCK_FIRST  = 8'h10;
  localparam logic [7:0] LOCK_LAST   = 8'h33;
  localparam logic [7:0] ROUTE_KEEP  = 8'h8F;
  localparam logic [7:0] ROUTE_RESET = 8'h80;

  // index of each rule byte inside the misc register file
  localparam int unsigned MI_CMD_LO = 0;
  localparam int unsigned MI_CMD_HI = 1;
  localparam int unsigned MI_STS_HI = 2;
  localparam int unsigned MI_WPROT  = 3;
  localparam int unsigned MI_AUX_A  = 4;
  localparam int unsigned MI_AUX_B  = 5;

  localparam logic [N_MISC*8-1:0] MISC_OFFS =
    {OFF_AUX_B, OFF_AUX_A, OFF_WPROT, OFF_STS_HI, OFF_CMD_HI, OFF_CMD_LO};
  localparam logic [N_MISC*8-1:0] MISC_RSTS =
    {8'h00, 8'h00, 8'h00, 8'h02, 8'h00, 8'h07};

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_DWALT = 2'd3
  } cfg_size_e;

  function automatic logic [LANES-1:0] lane_enables(input logic [1:0] lo,
                                                    input logic [1:0] sz);
    logic [2:0] nbytes;
    logic [2:0] first;
    logic [LANES-1:0] en;
    case (cfg_size_e'(sz))
      SZ_BYTE: nbytes = 3'd1;
      SZ_WORD: nbytes = 3'd2;
      default: nbytes = 3'd4;
    endcase
    first = {1'b0, lo};
    for (int k = 0; k < LANES; k++) begin
      en[k] = (3'(k) >= first) && ({1'b0, 3'(k)} < ({1'b0, first} + {1'b0, nbytes}));
    end
    return en;
  endfunction

  function automatic logic [31:0] align_wdata(input logic [31:0] d,
                                              input logic [1:0] lo);
    return d << {lo, 3'b000};
  endfunction

  function automatic logic [31:0] align_rdata(input logic [31:0] q,
                                              input logic [1:0] lo);
    return q >> {lo, 3'b000};
  endfunction

  function automatic logic write_locked(input logic [7:0] off);
    return (off == OFF_STS_LO) || ((off >= LOCK_FIRST) && (off <= LOCK_LAST));
  endfunction

  function automatic logic [7:0] misc_rule(input logic [7:0] off,
                                           input logic [7:0] old,
                                           input logic [7:0] d);
    logic [7:0] nxt;
    case (off)
      OFF_CMD_LO: nxt = (d & 8'h08) | 8'h07;
      OFF_CMD_HI: nxt = d & 8'h01;
      OFF_STS_HI: nxt = (old & ~(d & 8'h78)) | 8'h02;
      OFF_WPROT:  nxt = d & 8'h01;
      OFF_AUX_A:  nxt = d & 8'hD7;
      OFF_AUX_B:  nxt = d & 8'h7F;
      default:    nxt = old;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/irq_route_misc_regs.sv
module irq_route_misc_regs
  import irq_route_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [LANES-1:0]             lane_wr,
  input  logic [LANES-1:0][7:0]        lane_off,
  input  logic [LANES-1:0][7:0]        lane_data,
  output logic [N_MISC-1:0][7:0]       misc_q,
  output logic [N_MISC-1:0]            misc_strobe
);

  for (genvar i = 0; i < N_MISC; i++) begin : g_byte
    localparam logic [7:0] MY_OFF = MISC_OFFS[8*i +: 8];
    localparam logic [7:0] MY_RST = MISC_RSTS[8*i +: 8];
    logic       hit;
    logic [7:0] din;

    always_comb begin
      hit = 1'b0;
      din = 8'h00;
      for (int k = 0; k < LANES; k++) begin
        if (lane_wr[k] && (lane_off[k] == MY_OFF)) begin
          hit = 1'b1;
          din = lane_data[k];
        end
      end
    end

    assign misc_strobe[i] = hit;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        misc_q[i] <= MY_RST;
      end else if (hit) begin
        misc_q[i] <= misc_rule(MY_OFF, misc_q[i], din);
      end
    end
  end

endmodule

// File: rtl/irq_route_pirq_table.sv
module irq_route_pirq_table
  import irq_route_pkg::*;
#(
  parameter int unsigned      NUM_PIRQ   = 4,
  parameter int unsigned      NUM_IRQ    = 16,
  parameter logic [NUM_IRQ-1:0] LEGAL_MASK = 16'hDEF8,
  localparam int unsigned     IRQ_W      = $clog2(NUM_IRQ)
)(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_PIRQ-1:0]               pirq_wr,
  input  logic [NUM_PIRQ-1:0][7:0]          pirq_wdata,
  output logic [NUM_PIRQ-1:0][7:0]          route_q,
  output logic [NUM_IRQ-1:0][NUM_PIRQ-1:0]  irq_map_q,
  output logic [NUM_PIRQ-1:0]               route_accept,
  output logic [NUM_PIRQ-1:0]               route_disable,
  output logic [NUM_IRQ-1:0]                irq_busy
);

  logic [NUM_PIRQ-1:0][7:0]       masked;
  logic [NUM_PIRQ-1:0][IRQ_W-1:0] field;
  logic [NUM_PIRQ-1:0]            legal;

  for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_pirq
    assign masked[p]        = pirq_wdata[p] & ROUTE_KEEP;
    assign field[p]         = masked[p][IRQ_W-1:0];
    assign route_disable[p] = masked[p][7];
    assign legal[p]         = !masked[p][7] && LEGAL_MASK[field[p]];
    assign route_accept[p]  = pirq_wr[p] && (route_disable[p] || legal[p]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        route_q[p] <= ROUTE_RESET;
      end else if (route_accept[p]) begin
        route_q[p] <= masked[p];
      end
    end

    // reverse table: line p leaves every IRQ except its new target
    for (genvar n = 0; n < NUM_IRQ; n++) begin : g_irq
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          irq_map_q[n][p] <= 1'b0;
        end else if (route_accept[p]) begin
          irq_map_q[n][p] <= !route_disable[p] && (field[p] == IRQ_W'(n));
        end
      end
    end
  end

  for (genvar n = 0; n < NUM_IRQ; n++) begin : g_busy
    assign irq_busy[n] = |irq_map_q[n];
  end

endmodule

// File: rtl/irq_route_cfg.sv
module irq_route_cfg
  import irq_route_pkg::*;
#(
  parameter int unsigned        NUM_PIRQ   = 4,
  parameter int unsigned        NUM_IRQ    = 16,
  parameter logic [NUM_IRQ-1:0] LEGAL_MASK = 16'hDEF8
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [CFG_AW-1:0]  cfg_off,
  input  logic [1:0]         cfg_size,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  output logic [NUM_IRQ-1:0] irq_busy
);

  logic [LANES-1:0]                lane_en;
  logic [LANES-1:0]                lane_wr;
  logic [LANES-1:0][7:0]           lane_off;
  logic [LANES-1:0][7:0]           lane_data;
  logic [31:0]                     wdata_al;
  logic [LANES-1:0][7:0]           rd_bytes;

  logic [N_MISC-1:0][7:0]          misc_q;
  logic [N_MISC-1:0]               misc_strobe;
  logic [NUM_PIRQ-1:0]             pirq_wr;
  logic [NUM_PIRQ-1:0][7:0]        pirq_wdata;
  logic [NUM_PIRQ-1:0][7:0]        route_q;
  logic [NUM_IRQ-1:0][NUM_PIRQ-1:0] irq_map_q;
  logic [NUM_PIRQ-1:0]             route_accept;
  logic [NUM_PIRQ-1:0]             route_disable;
  logic [7:0]                      cmd_lo_q;
  logic [7:0]                      sts_hi_q;

  assign lane_en  = lane_enables(cfg_off[1:0], cfg_size);
  assign wdata_al = align_wdata(cfg_wdata, cfg_off[1:0]);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_off[k]  = {cfg_off[CFG_AW-1:2], 2'(k)};
    assign lane_data[k] = wdata_al[8*k +: 8];
    assign lane_wr[k]   = cfg_wr && lane_en[k] && !write_locked(lane_off[k]);
  end

  always_comb begin
    for (int p = 0; p < NUM_PIRQ; p++) begin
      pirq_wr[p]    = 1'b0;
      pirq_wdata[p] = 8'h00;
      for (int k = 0; k < LANES; k++) begin
        if (lane_wr[k] && (lane_off[k] == (ROUTE_BASE + 8'(p)))) begin
          pirq_wr[p]    = 1'b1;
          pirq_wdata[p] = lane_data[k];
        end
      end
    end
  end

  irq_route_misc_regs u_misc (
    .clk         (clk),
    .rst_n       (rst_n),
    .lane_wr     (lane_wr),
    .lane_off    (lane_off),
    .lane_data   (lane_data),
    .misc_q      (misc_q),
    .misc_strobe (misc_strobe)
  );

  irq_route_pirq_table #(
    .NUM_PIRQ   (NUM_PIRQ),
    .NUM_IRQ    (NUM_IRQ),
    .LEGAL_MASK (LEGAL_MASK)
  ) u_table (
    .clk           (clk),
    .rst_n         (rst_n),
    .pirq_wr       (pirq_wr),
    .pirq_wdata    (pirq_wdata),
    .route_q       (route_q),
    .irq_map_q     (irq_map_q),
    .route_accept  (route_accept),
    .route_disable (route_disable),
    .irq_busy      (irq_busy)
  );

  assign cmd_lo_q = misc_q[MI_CMD_LO];
  assign sts_hi_q = misc_q[MI_STS_HI];

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      rd_bytes[k] = 8'h00;
      for (int i = 0; i < N_MISC; i++) begin
        if (lane_off[k] == MISC_OFFS[8*i +: 8]) rd_bytes[k] = misc_q[i];
      end
      for (int p = 0; p < NUM_PIRQ; p++) begin
        if (lane_off[k] == (ROUTE_BASE + 8'(p))) rd_bytes[k] = route_q[p];
      end
    end
  end

  assign cfg_rdata = align_rdata(rd_bytes, cfg_off[1:0]);

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int unsigned        NUM_PIRQ   = 4,
  parameter int unsigned        NUM_IRQ    = 16,
  parameter logic [NUM_IRQ-1:0] LEGAL_MASK = 16'hDEF8,
  localparam int unsigned       IRQ_W      = $clog2(NUM_IRQ)
)(
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cfg_wr,
  input logic [NUM_IRQ-1:0]          irq_busy,
  input logic [NUM_PIRQ-1:0][7:0]    route_q,
  input logic [7:0]                  cmd_lo_q,
  input logic [7:0]                  sts_hi_q
);

  logic [NUM_IRQ-1:0] from_routes;

  always_comb begin
    from_routes = '0;
    for (int p = 0; p < NUM_PIRQ; p++) begin
      if (!route_q[p][7]) from_routes[route_q[p][IRQ_W-1:0]] = 1'b1;
    end
  end

  assert_busy_tracks_routes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_busy == from_routes);

  assert_busy_legal_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_busy & ~LEGAL_MASK) == '0);

  assert_busy_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_wr) |-> $stable(irq_busy));

  assert_cmd_forced_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_lo_q[2:0] == 3'b111) && (cmd_lo_q[7:4] == 4'h0));

  assert_status_bit1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sts_hi_q[1]);

  for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_route
    assert_route_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      route_q[p][6:4] == 3'b000);
    assert_route_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !route_q[p][7] |-> LEGAL_MASK[route_q[p][IRQ_W-1:0]]);
  end

endmodule

bind irq_route_cfg irq_route_chk #(
  .NUM_PIRQ   (NUM_PIRQ),
  .NUM_IRQ    (NUM_IRQ),
  .LEGAL_MASK (LEGAL_MASK)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_wr   (cfg_wr),
  .irq_busy (irq_busy),
  .route_q  (route_q),
  .cmd_lo_q (cmd_lo_q),
  .sts_hi_q (sts_hi_q)
);

// File: tb/irq_route_cfg_bench.sv
`timescale 1ns/1ps
module irq_route_cfg_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_off = 8'h00;
  logic [1:0]  cfg_size = 2'd0;
  logic [31:0] cfg_wdata = 32'h0;
  wire  [31:0] cfg_rdata;
  wire  [15:0] irq_busy;

  logic [7:0] mdl [0:255];
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [31:0] seed = 32'h1234_5679;

  always #2 clk = ~clk;

  irq_route_cfg u_irq_route_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_off   (cfg_off),
    .cfg_size  (cfg_size),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .irq_busy  (irq_busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic bit irq_ok(input int n);
    case (n)
      3, 4, 5, 6, 7, 9, 10, 11, 12, 14, 15: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] exp_busy();
    logic [31:0] e = 32'h0;
    for (int p = 0; p < 4; p++) begin
      if (mdl[8'h60 + p] < 8'h80) e[mdl[8'h60 + p] & 8'h0F] = 1'b1;
    end
    return e;
  endfunction

  task automatic model_reset();
    for (int a = 0; a < 256; a++) mdl[a] = 8'h00;
    mdl[8'h04] = 8'h07;
    mdl[8'h07] = 8'h02;
    for (int p = 0; p < 4; p++) mdl[8'h60 + p] = 8'h80;
  endtask

  task automatic model_write(input logic [7:0] off, input logic [1:0] sz, input logic [31:0] d);
    int nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    for (int i = 0; i < nb; i++) begin
      int pos = int'(off[1:0]) + i;
      logic [7:0] a;
      logic [7:0] b;
      if (pos > 3) break;
      a = {off[7:2], 2'b00} + 8'(pos);
      b = d[8*i +: 8];
      case (a)
        8'h04: mdl[a] = 8'h07 | (b & 8'h08);
        8'h05: mdl[a] = b & 8'h01;
        8'h07: mdl[a] = 8'h02 | (mdl[a] & ~(b & 8'h78));
        8'h4F: mdl[a] = b & 8'h01;
        8'h6A: mdl[a] = b & 8'hD7;
        8'h80: mdl[a] = b & 8'h7F;
        8'h60, 8'h61, 8'h62, 8'h63: begin
          if (b[7]) mdl[a] = b & 8'h8F;
          else if (irq_ok(int'(b[3:0]))) mdl[a] = b & 8'h8F;
        end
        default: ;
      endcase
    end
  endtask

  task automatic do_write(input logic [7:0] off, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_off = off; cfg_size = sz; cfg_wdata = d;
    #0.5;
    check("R5 busy before edge", {16'h0, irq_busy}, exp_busy());
    model_write(off, sz, d);
    @(negedge clk);
    cfg_wr = 1'b0;
    #0.5;
    check("R4 busy after write", {16'h0, irq_busy}, exp_busy());
  endtask

  task automatic check_read(input logic [7:0] off, input string req);
    logic [7:0] b;
    logic [31:0] e;
    cfg_off = off;
    #0.2;
    b = {off[7:2], 2'b00};
    e = {mdl[b + 8'd3], mdl[b + 8'd2], mdl[b + 8'd1], mdl[b]} >> (8 * int'(off[1:0]));
    check(req, cfg_rdata, e);
  endtask

  task automatic sweep(input string req);
    for (int d = 0; d < 64; d++) check_read(8'(d * 4 + (d % 4)), req);
  endtask

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  initial begin
    model_reset();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    sweep("R1 reset map");
    check("R1 reset busy", {16'h0, irq_busy}, 32'h0);

    // every byte value into every routing byte
    for (int p = 0; p < 4; p++) begin
      for (int v = 0; v < 256; v++) begin
        do_write(8'h60 + 8'(p), 2'd0, 32'(v));
        check_read(8'h60 + 8'(p), (v < 128) ? "R3 route accept" : "R2 route disable");
      end
    end

    // directed legal then illegal route
    do_write(8'h60, 2'd0, 32'h05);
    do_write(8'h60, 2'd0, 32'h08);
    check_read(8'h60, "R3 illegal kept");
    check("R3 busy kept", {16'h0, irq_busy}, 32'h0000_0020);
    do_write(8'h61, 2'd0, 32'h05);
    do_write(8'h60, 2'd0, 32'h0E);
    check("R4 shared then moved", {16'h0, irq_busy}, 32'h0000_4020);

    // rule bytes, all values
    for (int v = 0; v < 256; v++) begin
      do_write(8'h04, 2'd0, 32'(v)); check_read(8'h04, "R7 cmd low");
      do_write(8'h05, 2'd0, 32'(v)); check_read(8'h05, "R7 cmd high");
      do_write(8'h07, 2'd0, 32'(v)); check_read(8'h07, "R8 status high");
      do_write(8'h4F, 2'd0, 32'(v)); check_read(8'h4F, "R9 wprot");
      do_write(8'h6A, 2'd0, 32'(v)); check_read(8'h6A, "R9 aux 6A");
      do_write(8'h80, 2'd0, 32'(v)); check_read(8'h80, "R9 aux 80");
    end

    // multi-byte routing
    do_write(8'h60, 2'd2, 32'h0F0E0B03);
    check("R6 dword routes", {16'h0, irq_busy}, 32'h0000_C808);
    do_write(8'h62, 2'd3, 32'h0707_8585);
    check_read(8'h60, "R6 clipped dword");
    check("R6 clipped busy", {16'h0, irq_busy}, 32'h0000_0808);
    do_write(8'h61, 2'd1, 32'hAAAA_0C80);
    check_read(8'h61, "R6 word write");

    // ignored offsets
    do_write(8'h06, 2'd0, 32'hFF);
    do_write(8'h04, 2'd2, 32'hFFFF_FFFF);
    for (int a = 8'h10; a < 8'h34; a += 4) do_write(8'(a), 2'd2, 32'hFFFF_FFFF);
    sweep("R10 ignored");

    // random accesses
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] r = rnd();
      logic [7:0] off = r[7:0];
      if (r[8]) off = {6'b011000, r[10:9]};
      do_write(off, r[12:11], rnd());
      check_read({off[7:2], r[14:13]}, "R6 random");
      if (i % 250 == 249) sweep("R10 random map");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule